// File: doc/BRIEF.md
# Gapped SPI Command Master

This block is an SPI master for peripherals whose serial decoder needs a minimum amount of time to digest each byte before the next one may arrive. The host loads a command buffer and asserts a start pulse. The buffer holds the number of command bytes, the command bytes themselves and the number of bytes to read back. The master then runs a single session with chip select held low throughout. It shifts out the command bytes, then sends dummy bytes so the peripheral can shift out its response, and stores every returned byte in a receive buffer.

The spacing rule is expressed in system-clock cycles. `decodeCycles` is the shortest allowed time from the end of one byte to the end of the next. `halfDiv` is the SCLK half-period. One byte on the wire lasts 16·halfDiv cycles. When that is already at least `decodeCycles`, the bytes follow each other with no pause. Otherwise the master inserts an idle gap with SCLK low, and the gap is exactly long enough to meet the minimum. Bursts use SPI mode 1: SCLK idles low, MOSI changes on the rising edge, and MISO is sampled on the falling edge, MSB first.

Top module: `spiCmdMaster`

## Requirements
- R1: After reset, and whenever no session is running, csn is 1, sclk is 0, mosi is 0, and busy and done are 0.
- R2: Every session sends command byte i from txData[8i+7:8i] in ascending i, MSB first, followed by one 0x00 byte per read-back byte.
- R3: SCLK runs in bursts of exactly eight pulses per byte. Each pulse is high for halfDiv cycles and then low for halfDiv cycles. mosi changes only in the cycle in which sclk rises.
- R4: MISO is sampled on each falling sclk edge, MSB first. Read-back byte j is stored at rxData[8j+7:8j] and is held there after the session ends.
- R5: The time from the last falling edge of one byte to the last falling edge of the next equals max(16·halfDiv, decodeCycles) cycles.
- R6: csn falls on the edge that accepts start and stays low without a break until the session ends. The first rising sclk edge comes exactly halfDiv cycles after csn falls.
- R7: csn rises exactly halfDiv cycles after the last falling sclk edge. done is 1 for exactly that one cycle, and busy falls in the next cycle.
- R8: A start request made while busy is 1 is ignored, including one made in the done cycle. It does not change the running session or its bytes, and it does not begin another session.
- R9: A start request with txCount equal to 0 is ignored: busy stays 0 and csn stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Session request, accepted only when idle |
| txCount | input | 3 | Number of command bytes (1..4) |
| rxCount | input | 3 | Number of read-back bytes (0..4) |
| txData | input | 32 | Command bytes, byte i at bits 8i+7:8i |
| halfDiv | input | 8 | SCLK half-period in system cycles (1 or more) |
| decodeCycles | input | 12 | Minimum end-to-end byte spacing in system cycles |
| busy | output | 1 | Session in progress, through the done cycle |
| done | output | 1 | One-cycle pulse when the session ends |
| rxData | output | 32 | Read-back bytes, byte j at bits 8j+7:8j |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the peripheral |
| csn | output | 1 | Active-low chip select |
| miso | input | 1 | Serial data from the peripheral |

## Verification
The end of a session and a new request can fall in the same cycle. In the cycle where done and the csn release occur, the bench asserts start again and holds it only for that cycle. The request must be ignored: busy must be 0 afterwards, csn must stay high, and no extra bytes may appear on the bus. A request in the very next cycle must then start a normal session. A second provocation asserts start in the middle of a session with different txData and counts. The scoreboard then confirms that the bytes on the wire and the stored response still match the original request.

// File: rtl/spiCmdPkg.sv
package spiCmdPkg;
  typedef struct packed {
    logic latch;
    logic loadByte;
    logic rise;
    logic fall;
    logic storeRx;
    logic endSession;
  } spiStrobes_t;
endpackage

// File: rtl/spiCmdCtrl.sv
module spiCmdCtrl
  import spiCmdPkg::*;
#(
  parameter int MAX_BYTES = 4,
  parameter int HDW = 8,
  parameter int DECW = 12,
  localparam int CW = $clog2(MAX_BYTES + 1),
  localparam int IW = $clog2(2 * MAX_BYTES),
  localparam int RW = $clog2(MAX_BYTES),
  localparam int XW = IW + CW,
  localparam int CNTW = (DECW > HDW + 4) ? DECW : HDW + 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [CW-1:0]   txCount,
  input  logic [CW-1:0]   rxCount,
  input  logic [HDW-1:0]  halfDiv,
  input  logic [DECW-1:0] decodeCycles,
  output spiStrobes_t     strobe,
  output logic [IW-1:0]   loadIdx,
  output logic            loadRead,
  output logic [RW-1:0]   rxIdx,
  output logic            busy,
  output logic            done
);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_HIGH, S_LOW, S_GAP, S_FIN} ctrlState_t;

  ctrlState_t      state;
  logic [CNTW-1:0] cnt;
  logic [CNTW-1:0] hd;
  logic [CNTW-1:0] gapLen;
  logic [2:0]      bitCnt;
  logic [IW-1:0]   byteIdx;
  logic [IW-1:0]   lastIdx;
  logic [CW-1:0]   txCnt;

  logic [CNTW-1:0] hdIn;
  logic [CNTW-1:0] byteTime;
  logic [CNTW-1:0] decodeExt;
  logic [CNTW-1:0] gapCalc;
  logic            accept;
  logic            cntZero;
  logic            lastBit;
  logic            curRead;

  assign hdIn      = CNTW'(halfDiv);
  assign byteTime  = hdIn << 4;
  assign decodeExt = CNTW'(decodeCycles);
  assign gapCalc   = (decodeExt > byteTime) ? (decodeExt - byteTime) : '0;
  assign accept    = (state == S_IDLE) && start && (txCount != '0);
  assign cntZero   = (cnt == '0);
  assign lastBit   = (bitCnt == 3'd7);
  assign curRead   = XW'(byteIdx) >= XW'(txCnt);

  assign loadIdx  = (state == S_LOW) ? byteIdx + IW'(1) : byteIdx;
  assign loadRead = XW'(loadIdx) >= XW'(txCnt);
  assign rxIdx    = RW'(byteIdx - IW'(txCnt));
  assign busy     = (state != S_IDLE);
  assign done     = (state == S_FIN);

  always_comb begin
    strobe = '0;
    strobe.latch = accept;
    unique case (state)
      S_SETUP: if (cntZero) begin
        strobe.loadByte = 1'b1;
        strobe.rise     = 1'b1;
      end
      S_HIGH: if (cntZero) begin
        strobe.fall    = 1'b1;
        strobe.storeRx = lastBit && curRead;
      end
      S_LOW: if (cntZero) begin
        if (!lastBit) begin
          strobe.rise = 1'b1;
        end else if (byteIdx == lastIdx) begin
          strobe.endSession = 1'b1;
        end else if (gapLen == '0) begin
          strobe.loadByte = 1'b1;
          strobe.rise     = 1'b1;
        end
      end
      S_GAP: if (cntZero) begin
        strobe.loadByte = 1'b1;
        strobe.rise     = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      cnt     <= '0;
      hd      <= '0;
      gapLen  <= '0;
      bitCnt  <= '0;
      byteIdx <= '0;
      lastIdx <= '0;
      txCnt   <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (accept) begin
          state   <= S_SETUP;
          cnt     <= hdIn - CNTW'(1);
          hd      <= hdIn;
          gapLen  <= gapCalc;
          txCnt   <= txCount;
          lastIdx <= IW'(XW'(txCount) + XW'(rxCount) - XW'(1));
          byteIdx <= '0;
          bitCnt  <= '0;
        end
        S_SETUP, S_HIGH, S_GAP: begin
          if (cntZero) begin
            state <= (state == S_HIGH) ? S_LOW : S_HIGH;
            cnt   <= hd - CNTW'(1);
          end else begin
            cnt <= cnt - CNTW'(1);
          end
        end
        S_LOW: begin
          if (!cntZero) begin
            cnt <= cnt - CNTW'(1);
          end else if (!lastBit) begin
            bitCnt <= bitCnt + 3'd1;
            state  <= S_HIGH;
            cnt    <= hd - CNTW'(1);
          end else if (byteIdx == lastIdx) begin
            state <= S_FIN;
          end else begin
            byteIdx <= byteIdx + IW'(1);
            bitCnt  <= '0;
            if (gapLen == '0) begin
              state <= S_HIGH;
              cnt   <= hd - CNTW'(1);
            end else begin
              state <= S_GAP;
              cnt   <= gapLen - CNTW'(1);
            end
          end
        end
        S_FIN: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spiCmdDatapath.sv
module spiCmdDatapath
  import spiCmdPkg::*;
#(
  parameter int MAX_BYTES = 4,
  localparam int IW = $clog2(2 * MAX_BYTES),
  localparam int RW = $clog2(MAX_BYTES),
  localparam int BUFW = 8 * MAX_BYTES
) (
  input  logic            clk,
  input  logic            rstN,
  input  spiStrobes_t     strobe,
  input  logic [BUFW-1:0] txData,
  input  logic [IW-1:0]   loadIdx,
  input  logic            loadRead,
  input  logic [RW-1:0]   rxIdx,
  input  logic            miso,
  output logic            sclk,
  output logic            mosi,
  output logic            csn,
  output logic [BUFW-1:0] rxData
);

  logic [7:0] txBytes [MAX_BYTES];
  logic [7:0] rxBytes [MAX_BYTES];
  logic [7:0] txShift;
  logic [7:0] rxShift;
  logic [7:0] nextByte;
  logic [7:0] rxWord;

  assign nextByte = loadRead ? 8'h00 : txBytes[RW'(loadIdx)];
  assign rxWord   = {rxShift[6:0], miso};

  generate
    for (genvar g = 0; g < MAX_BYTES; g++) begin : g_rxOut
      assign rxData[g*8 +: 8] = rxBytes[g];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MAX_BYTES; i++) txBytes[i] <= '0;
    end else if (strobe.latch) begin
      for (int i = 0; i < MAX_BYTES; i++) txBytes[i] <= txData[i*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclk    <= 1'b0;
      mosi    <= 1'b0;
      csn     <= 1'b1;
      txShift <= '0;
    end else begin
      if (strobe.latch) csn <= 1'b0;
      else if (strobe.endSession) csn <= 1'b1;

      if (strobe.rise) sclk <= 1'b1;
      else if (strobe.fall) sclk <= 1'b0;

      if (strobe.rise && strobe.loadByte) begin
        mosi    <= nextByte[7];
        txShift <= {nextByte[6:0], 1'b0};
      end else if (strobe.rise) begin
        mosi    <= txShift[7];
        txShift <= {txShift[6:0], 1'b0};
      end else if (strobe.endSession || strobe.latch) begin
        mosi <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      for (int i = 0; i < MAX_BYTES; i++) rxBytes[i] <= '0;
    end else if (strobe.fall) begin
      rxShift <= rxWord;
      if (strobe.storeRx) rxBytes[rxIdx] <= rxWord;
    end
  end

endmodule

// File: rtl/spiCmdMaster.sv
module spiCmdMaster
  import spiCmdPkg::*;
#(
  parameter int MAX_BYTES = 4,
  parameter int HDW = 8,
  parameter int DECW = 12,
  localparam int CW = $clog2(MAX_BYTES + 1),
  localparam int IW = $clog2(2 * MAX_BYTES),
  localparam int RW = $clog2(MAX_BYTES),
  localparam int BUFW = 8 * MAX_BYTES
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [CW-1:0]   txCount,
  input  logic [CW-1:0]   rxCount,
  input  logic [BUFW-1:0] txData,
  input  logic [HDW-1:0]  halfDiv,
  input  logic [DECW-1:0] decodeCycles,
  output logic            busy,
  output logic            done,
  output logic [BUFW-1:0] rxData,
  output logic            sclk,
  output logic            mosi,
  output logic            csn,
  input  logic            miso
);

  spiStrobes_t   strobe;
  logic [IW-1:0] loadIdx;
  logic          loadRead;
  logic [RW-1:0] rxIdx;

  spiCmdCtrl #(.MAX_BYTES(MAX_BYTES), .HDW(HDW), .DECW(DECW)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .txCount(txCount), .rxCount(rxCount),
    .halfDiv(halfDiv), .decodeCycles(decodeCycles), .strobe(strobe),
    .loadIdx(loadIdx), .loadRead(loadRead), .rxIdx(rxIdx), .busy(busy), .done(done)
  );

  spiCmdDatapath #(.MAX_BYTES(MAX_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txData(txData), .loadIdx(loadIdx),
    .loadRead(loadRead), .rxIdx(rxIdx), .miso(miso), .sclk(sclk), .mosi(mosi),
    .csn(csn), .rxData(rxData)
  );

endmodule

// File: rtl/spiCmdMasterChk.sv
module spiCmdMasterChk (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic done,
  input logic sclk,
  input logic mosi,
  input logic csn
);

  // R1
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (csn && !sclk && !mosi && !done));

  // R3
  mosi_rise_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && !done && !$rose(sclk)) |-> $stable(mosi));

  // R6
  cs_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> !csn);

  // R7
  release_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csn) |-> done);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

endmodule

bind spiCmdMaster spiCmdMasterChk u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done),
  .sclk(sclk), .mosi(mosi), .csn(csn)
);

// File: tb/spiCmdMaster_bench.sv
module spiCmdMaster_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  txCount = '0;
  logic [2:0]  rxCount = '0;
  logic [31:0] txData = '0;
  logic [7:0]  halfDiv = 8'd1;
  logic [11:0] decodeCycles = '0;
  logic        busy, done, sclk, mosi, csn;
  logic [31:0] rxData;
  logic        miso = 1'b0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [7:0] expMosi[$];
  logic [7:0] expRx[$];
  logic [7:0] slaveArr [8];
  int curHd = 1;
  int expSpace = 16;
  int curRc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spiCmdMaster u_spiCmdMaster (
    .clk(clk), .rstN(rstN), .start(start), .txCount(txCount), .rxCount(rxCount),
    .txData(txData), .halfDiv(halfDiv), .decodeCycles(decodeCycles), .busy(busy),
    .done(done), .rxData(rxData), .sclk(sclk), .mosi(mosi), .csn(csn), .miso(miso)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor and peripheral model
  logic prevSclk = 1'b0;
  logic prevCsn = 1'b1;
  int csnFallCyc = 0, riseCyc = 0, lastEnd = 0;
  int bitsIn = 0, byteN = 0, slaveIdx = 0, slaveBit = 0;
  logic firstRise = 1'b0;
  logic [7:0] mosiSh = '0;

  always @(negedge clk) begin
    if (rstN) begin
      if (prevCsn && !csn) begin
        csnFallCyc = cyc; firstRise = 1'b1;
        bitsIn = 0; byteN = 0; slaveIdx = 0; slaveBit = 0;
      end
      if (!prevSclk && sclk) begin
        if (firstRise) begin
          chk("R6 setup", cyc - csnFallCyc, curHd);
          firstRise = 1'b0;
        end
        riseCyc = cyc;
        miso = slaveArr[slaveIdx][7 - slaveBit];
        slaveBit++;
        if (slaveBit == 8) begin slaveBit = 0; slaveIdx++; end
      end
      if (prevSclk && !sclk) begin
        chk("R3 high width", cyc - riseCyc, curHd);
        mosiSh = {mosiSh[6:0], mosi};
        bitsIn++;
        if (bitsIn == 8) begin
          bitsIn = 0;
          if (expMosi.size() == 0) chk("R2 extra byte", {24'h0, mosiSh}, 32'hDEAD);
          else chk("R2 mosi byte", {24'h0, mosiSh}, {24'h0, expMosi.pop_front()});
          if (byteN > 0) chk("R5 spacing", cyc - lastEnd, expSpace);
          lastEnd = cyc;
          byteN++;
        end
      end
      if (!prevCsn && csn) begin
        chk("R7 hold", cyc - lastEnd, curHd);
        chk("R7 done with release", {31'h0, done}, 32'h1);
        chk("R2 byte count", expMosi.size(), 0);
        for (int j = 0; j < curRc; j++) begin
          if (expRx.size() > 0) chk("R4 rx byte", {24'h0, rxData[8*j +: 8]}, {24'h0, expRx.pop_front()});
        end
      end
    end
    prevSclk = sclk;
    prevCsn = csn;
  end

  task automatic waitDone();
    do @(negedge clk); while (!done);
  endtask

  // driver: pushes expectations, then requests a session
  task automatic runCmd(input int tc, input int rc, input int hd, input int dec,
                        input logic [31:0] txw, input logic [31:0] resp,
                        input bit pokeMid, input bit pokeDone);
    for (int i = 0; i < tc; i++) begin
      expMosi.push_back(txw[8*i +: 8]);
      slaveArr[i] = 8'hA5 ^ 8'(i);
    end
    for (int j = 0; j < rc; j++) begin
      expMosi.push_back(8'h00);
      expRx.push_back(resp[8*j +: 8]);
      slaveArr[tc + j] = resp[8*j +: 8];
    end
    curHd = hd; curRc = rc;
    expSpace = (16 * hd > dec) ? 16 * hd : dec;
    @(negedge clk);
    txCount = 3'(tc); rxCount = 3'(rc); txData = txw;
    halfDiv = 8'(hd); decodeCycles = 12'(dec);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (pokeMid) begin
      repeat (20) @(negedge clk);
      txCount = 3'd1; rxCount = 3'd0; txData = 32'hFFFF_FFFF; halfDiv = 8'd3;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    waitDone();
    if (pokeDone) begin
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      chk("R8 done-cycle start ignored busy", {31'h0, busy}, 32'h0);
      chk("R8 done-cycle start ignored csn", {31'h0, csn}, 32'h1);
    end else begin
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) slaveArr[i] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset csn", {31'h0, csn}, 32'h1);
    chk("R1 reset sclk", {31'h0, sclk}, 32'h0);
    chk("R1 reset mosi", {31'h0, mosi}, 32'h0);
    chk("R1 reset busy", {31'h0, busy}, 32'h0);
    chk("R1 reset done", {31'h0, done}, 32'h0);

    // register-read style: two command bytes, one response, gap needed
    runCmd(2, 1, 1, 64, 32'h0000_0020, 32'h0000_0092, 1'b0, 1'b0);
    // slow clock: byte time exceeds decode, back to back, mid-session start
    runCmd(3, 2, 4, 40, 32'h00C3_5A81, 32'h0000_3CE7, 1'b1, 1'b0);
    chk("R8 mid-session start: no new session", {31'h0, busy}, 32'h0);
    // single byte, start held in done cycle
    runCmd(1, 0, 2, 32, 32'h0000_00B4, 32'h0, 1'b0, 1'b1);
    // back-to-back session right after ignored done-cycle request
    runCmd(4, 4, 1, 100, 32'h8040_2010, 32'h0F1E_2D3C, 1'b0, 1'b0);
    // byte time equals decode time exactly
    runCmd(2, 1, 2, 32, 32'h0000_7E01, 32'h0000_00AA, 1'b0, 1'b0);

    // R9: zero command bytes
    @(negedge clk);
    txCount = 3'd0; rxCount = 3'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 zero-count busy", {31'h0, busy}, 32'h0);
    chk("R9 zero-count csn", {31'h0, csn}, 32'h1);
    chk("R4 rx held after session", rxData[7:0], 32'hAA);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule